// File: doc/BRIEF.md
# Boot Lock and Fuse Access Unit

This unit keeps the six lock bits of a program memory and gives software a timed way to read the lock byte and the two fuse bytes. Software first writes a control word with both the lock-select and enable bits set. This opens a short window. A load in the first three cycles returns a configuration byte chosen by the load address. A store in the first four cycles programs boot lock bits. Outside the window, loads and stores go to program memory as usual. Each access is checked against the protection mode that the lock bits encode, and against the section that is executing.

A 2-bit boot-size code sets where the boot section starts. Every word address at or above that start is in the boot section, and every lower address is in the application section. Programming can only clear lock bits. A chip-erase input is the only way to return them to 1. The lock bits reset to all ones. A rejected store raises a flag and issues no backend request. A rejected load returns 0xFF.

Top module: `boot_lock_fuse_unit`

## Requirements
- R1: After reset, all lock bits are unprogrammed. A window read of the lock byte returns 0xFF, and no store request or reject is raised while the unit is idle.
- R2: A load in the window returns the selected byte. Load address 0x0000 returns the fuse low byte. Address 0x0001 returns the lock byte, with bits 7..6 = 11, bits 5..2 = the boot lock bits and bits 1..0 = the memory lock bits. Address 0x0003 returns the fuse high byte. Any other address returns 0xFF.
- R3: The load window covers the three cycles after the arming write. A load in the fourth cycle is an ordinary program-memory load. Any write to the control word that does not set both bits closes the window.
- R4: A store in one of the four cycles after the arming write programs a lock bit at position 5..2 when the matching bit of the store mask is 0. Such a store raises neither the request nor the reject output. A store in the fifth cycle is an ordinary program-memory store.
- R5: A lock bit that is 0 stays 0 when a mask bit of 1 is written to it. Only chip erase sets the lock bits back to 1.
- R6: Each section has a pair of lock bits: bits 3..2 for the application section and bits 5..4 for the boot section. When the low bit of a pair (bit 2 or bit 4) is 0, a store into that section raises the reject output and no request. Otherwise the store raises the request output.
- R7: When bit 3 is 0, a load that executes from the boot section and targets the application section returns 0xFF. When bit 5 is 0, a load that executes from the application section and targets the boot section returns 0xFF. A load within a single section always returns program-memory data.
- R8: Boot-size codes 11, 10, 01 and 00 put the boot start at word 0xF80, 0xF00, 0xE00 and 0xC00, shown on the boot-start output. The section check of R6 and R7 uses this boundary. The load word address is taken from load address bits 12..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_erase_i | input | 1 | Sets all lock bits back to 1 |
| boot_size_i | input | 2 | Boot-size configuration code |
| fuse_lo_i | input | 8 | Fuse low byte |
| fuse_hi_i | input | 8 | Fuse high byte |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| ctl_lockset_i | input | 1 | Control word lock-select bit |
| ctl_en_i | input | 1 | Control word enable bit |
| st_i | input | 1 | Store request |
| st_addr_i | input | 12 | Store word address |
| st_mask_i | input | 4 | Lock programming mask for bits 5..2, active low |
| ld_i | input | 1 | Load request |
| ld_z_i | input | 16 | Load byte address |
| ld_from_boot_i | input | 1 | Load executes from the boot section |
| flash_rdata_i | input | 8 | Program-memory read data |
| ld_data_o | output | 8 | Load result |
| st_req_o | output | 1 | Store request passed to the backend |
| st_rej_o | output | 1 | Store rejected by protection |
| boot_start_o | output | 12 | First word of the boot section |

## Verification
Load data, store request and reject are combinational in the cycle of the access. The bench drives each access on a falling edge and samples one nanosecond later, before the next rising edge. The window opens on the rising edge that captures the arming write. The bench therefore counts window cycles from the falling edge after that write and places accesses in cycles three and four, or four and five, to test each boundary. A lock update or chip erase takes effect on the next rising edge. The bench reads it back through a fresh window afterwards.

// File: rtl/blfu_pkg.sv
`timescale 1ns/1ps
package blfu_pkg;
  typedef struct packed {
    logic st_blk;
    logic ld_blk;
  } prot_t;

  // pair = {upper, lower}: lower 0 stops stores, upper 0 stops cross-section loads
  function automatic prot_t prot_decode(input logic [1:0] pair);
    prot_t p;
    p.st_blk = ~pair[0];
    p.ld_blk = ~pair[1];
    return p;
  endfunction
endpackage

// File: rtl/blfu_rst_sync.sv
`timescale 1ns/1ps
module blfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/blfu_window.sv
`timescale 1ns/1ps
module blfu_window #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic disarm_i,
  input  logic ld_i,
  input  logic st_i,
  output logic ld_ok_o,
  output logic st_ok_o
);
  localparam int CW = $clog2(ST_WIN + 1);
  localparam logic [CW-1:0] FULL  = CW'(ST_WIN);
  localparam logic [CW-1:0] LD_TH = CW'(ST_WIN - LD_WIN);

  logic [CW-1:0] cnt_q, cnt_d;

  assign ld_ok_o = cnt_q > LD_TH;
  assign st_ok_o = cnt_q != '0;

  always_comb begin
    cnt_d = cnt_q;
    if (arm_i)                                      cnt_d = FULL;
    else if (disarm_i)                              cnt_d = '0;
    else if ((ld_i && ld_ok_o) || (st_i && st_ok_o)) cnt_d = '0;
    else if (cnt_q != '0)                           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_arm_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (ld_ok_o && st_ok_o));
  assert_ld_within_st_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok_o |-> st_ok_o);
endmodule

// File: rtl/blfu_lock_reg.sv
`timescale 1ns/1ps
module blfu_lock_reg #(
  parameter int LOCK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              prog_i,
  input  logic [3:0]        mask_i,
  output logic [LOCK_W-1:0] lock_o
);
  logic [LOCK_W-1:0] lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (erase_i)     lock_d = '1;
    else if (prog_i) lock_d = lock_q & {mask_i, 2'b11};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '1;
    else        lock_q <= lock_d;
  end

  assign lock_o = lock_q;

  assert_one_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(erase_i) |-> ((lock_q & ~$past(lock_q)) == '0));
endmodule

// File: rtl/blfu_section.sv
`timescale 1ns/1ps
module blfu_section #(
  parameter int ADDR_W   = 12,
  parameter int MIN_BOOT = 128
) (
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] ld_word_i,
  input  logic [ADDR_W-1:0] st_word_i,
  output logic [ADDR_W-1:0] boot_start_o,
  output logic              ld_in_boot_o,
  output logic              st_in_boot_o
);
  logic [ADDR_W-1:0] boot_words;

  always_comb begin
    boot_words   = ADDR_W'(MIN_BOOT) << (~size_i);
    boot_start_o = '0 - boot_words;
    ld_in_boot_o = ld_word_i >= boot_start_o;
    st_in_boot_o = st_word_i >= boot_start_o;
  end
endmodule

// File: rtl/boot_lock_fuse_unit.sv
`timescale 1ns/1ps
module boot_lock_fuse_unit #(
  parameter int ADDR_W   = 12,
  parameter int Z_W      = 16,
  parameter int MIN_BOOT = 128,
  parameter int LD_WIN   = 3,
  parameter int ST_WIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_erase_i,
  input  logic [1:0]        boot_size_i,
  input  logic [7:0]        fuse_lo_i,
  input  logic [7:0]        fuse_hi_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_lockset_i,
  input  logic              ctl_en_i,
  input  logic              st_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [3:0]        st_mask_i,
  input  logic              ld_i,
  input  logic [Z_W-1:0]    ld_z_i,
  input  logic              ld_from_boot_i,
  input  logic [7:0]        flash_rdata_i,
  output logic [7:0]        ld_data_o,
  output logic              st_req_o,
  output logic              st_rej_o,
  output logic [ADDR_W-1:0] boot_start_o
);
  import blfu_pkg::*;

  localparam int LOCK_W = 6;
  localparam logic [Z_W-1:0] Z_FLO  = Z_W'(0);
  localparam logic [Z_W-1:0] Z_LOCK = Z_W'(1);
  localparam logic [Z_W-1:0] Z_FHI  = Z_W'(3);

  logic              rst_sn;
  logic              arm, disarm, ld_ok, st_ok;
  logic [LOCK_W-1:0] lock;
  logic              ld_in_boot, st_in_boot;
  logic              lock_prog, flash_st, st_blocked, ld_blocked;
  prot_t             app_p, boot_p;
  logic [7:0]        cfg_byte;

  blfu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign arm    = ctl_wr_i && ctl_lockset_i && ctl_en_i;
  assign disarm = ctl_wr_i && !arm;

  blfu_window #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_win (
    .clk(clk), .rst_n(rst_sn), .arm_i(arm), .disarm_i(disarm),
    .ld_i(ld_i), .st_i(st_i), .ld_ok_o(ld_ok), .st_ok_o(st_ok)
  );

  assign lock_prog = st_i && st_ok;
  assign flash_st  = st_i && !st_ok;

  blfu_lock_reg #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_sn), .erase_i(chip_erase_i),
    .prog_i(lock_prog), .mask_i(st_mask_i), .lock_o(lock)
  );

  blfu_section #(.ADDR_W(ADDR_W), .MIN_BOOT(MIN_BOOT)) u_sec (
    .size_i(boot_size_i), .ld_word_i(ld_z_i[ADDR_W:1]), .st_word_i(st_addr_i),
    .boot_start_o(boot_start_o), .ld_in_boot_o(ld_in_boot), .st_in_boot_o(st_in_boot)
  );

  always_comb begin
    app_p  = prot_decode(lock[3:2]);
    boot_p = prot_decode(lock[5:4]);
    st_blocked = st_in_boot ? boot_p.st_blk : app_p.st_blk;
    ld_blocked = ld_from_boot_i ? (!ld_in_boot && app_p.ld_blk)
                                : (ld_in_boot && boot_p.ld_blk);
    case (ld_z_i)
      Z_FLO:   cfg_byte = fuse_lo_i;
      Z_LOCK:  cfg_byte = {2'b11, lock};
      Z_FHI:   cfg_byte = fuse_hi_i;
      default: cfg_byte = 8'hFF;
    endcase
    if (ld_i && ld_ok)           ld_data_o = cfg_byte;
    else if (ld_i && ld_blocked) ld_data_o = 8'hFF;
    else                         ld_data_o = flash_rdata_i;
    st_req_o = flash_st && !st_blocked;
    st_rej_o = flash_st && st_blocked;
  end

  assert_req_rej_excl_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !(st_req_o && st_rej_o));
  assert_lockset_silent_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_i && st_ok) |-> !(st_req_o || st_rej_o));
  assert_boot_to_app_ff_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (ld_i && !ld_ok && ld_from_boot_i && !ld_in_boot && !lock[3]) |-> ld_data_o == 8'hFF);
  assert_lock_top_ones_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (ld_i && ld_ok && ld_z_i == Z_LOCK) |-> ld_data_o[7:6] == 2'b11);
endmodule

// File: tb/test_boot_lock_fuse_unit.sv
`timescale 1ns/1ps
module test_boot_lock_fuse_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_erase_i = 0;
  logic [1:0] boot_size_i = 2'b11;
  logic [7:0] fuse_lo_i = 8'hA5, fuse_hi_i = 8'h3C, flash_rdata_i = 8'h5A;
  logic ctl_wr_i = 0, ctl_lockset_i = 0, ctl_en_i = 0;
  logic st_i = 0;
  logic [11:0] st_addr_i = '0;
  logic [3:0] st_mask_i = 4'hF;
  logic ld_i = 0;
  logic [15:0] ld_z_i = '0;
  logic ld_from_boot_i = 0;
  logic [7:0] ld_data_o;
  logic st_req_o, st_rej_o;
  logic [11:0] boot_start_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_lock_fuse_unit i_boot_lock_fuse_unit (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    ctl_wr_i = 1; ctl_lockset_i = 1; ctl_en_i = 1;
    @(negedge clk);
    ctl_wr_i = 0; ctl_lockset_i = 0; ctl_en_i = 0;
  endtask

  task automatic do_ld(input logic [15:0] z, input logic fb, output logic [7:0] d);
    ld_i = 1; ld_z_i = z; ld_from_boot_i = fb;
    #1 d = ld_data_o;
    @(negedge clk);
    ld_i = 0;
  endtask

  task automatic do_st(input logic [11:0] a, input logic [3:0] m,
                       output logic rq, output logic rj);
    st_i = 1; st_addr_i = a; st_mask_i = m;
    #1 rq = st_req_o; rj = st_rej_o;
    @(negedge clk);
    st_i = 0; st_mask_i = 4'hF;
  endtask

  task automatic read_lock(output logic [7:0] d);
    arm();
    do_ld(16'h0001, 0, d);
  endtask

  task automatic prog_lock(input logic [3:0] m);
    logic rq, rj;
    arm();
    do_st(12'h000, m, rq, rj);
  endtask

  task automatic erase();
    chip_erase_i = 1;
    @(negedge clk);
    chip_erase_i = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #1 chk("R1 idle req", st_req_o, 0);
    chk("R1 idle rej", st_rej_o, 0);
    read_lock(d);
    chk("R1 lock after reset", d, 8'hFF);
  endtask

  task automatic t_reads();
    logic [7:0] d;
    arm(); do_ld(16'h0000, 0, d); chk("R2 fuse low", d, 8'hA5);
    arm(); do_ld(16'h0003, 0, d); chk("R2 fuse high", d, 8'h3C);
    arm(); do_ld(16'h0002, 0, d); chk("R2 unmapped", d, 8'hFF);
  endtask

  task automatic t_window();
    logic [7:0] d;
    arm(); idle(2); do_ld(16'h0000, 0, d); chk("R3 third cycle", d, 8'hA5);
    arm(); idle(3); do_ld(16'h0000, 0, d); chk("R3 fourth cycle", d, 8'h5A);
    arm();
    ctl_wr_i = 1; ctl_en_i = 1; @(negedge clk); ctl_wr_i = 0; ctl_en_i = 0;
    do_ld(16'h0000, 0, d); chk("R3 closed by write", d, 8'h5A);
  endtask

  task automatic t_lockset();
    logic rq, rj;
    logic [7:0] d;
    arm(); idle(3); do_st(12'h000, 4'b1110, rq, rj);
    chk("R4 lockset req", rq, 0);
    chk("R4 lockset rej", rj, 0);
    read_lock(d); chk("R4 lock programmed", d, 8'hFB);
    arm(); idle(4); do_st(12'hF80, 4'b0000, rq, rj);
    chk("R4 fifth cycle store", rq, 1);
    read_lock(d); chk("R4 lock unchanged", d, 8'hFB);
  endtask

  task automatic t_store_prot();
    logic rq, rj;
    logic [7:0] d;
    do_st(12'h100, 4'hF, rq, rj);
    chk("R6 app store rej", rj, 1);
    chk("R6 app store req", rq, 0);
    do_st(12'hF80, 4'hF, rq, rj);
    chk("R6 boot store req", rq, 1);
    do_ld(16'h0200, 1, d);
    chk("R7 load allowed mode10", d, 8'h5A);
  endtask

  task automatic t_oneway();
    logic rq, rj;
    logic [7:0] d;
    prog_lock(4'hF);
    read_lock(d); chk("R5 ones keep zero", d, 8'hFB);
    prog_lock(4'b1011);
    read_lock(d); chk("R5 accumulate", d, 8'hEB);
    do_st(12'hF80, 4'hF, rq, rj);
    chk("R6 boot store rej", rj, 1);
    erase();
    read_lock(d); chk("R5 chip erase", d, 8'hFF);
  endtask

  task automatic t_load_prot();
    logic rq, rj;
    logic [7:0] d;
    prog_lock(4'b1101);
    do_ld(16'h0200, 1, d); chk("R7 boot->app blocked", d, 8'hFF);
    do_ld(16'h0200, 0, d); chk("R7 app->app ok", d, 8'h5A);
    do_ld(16'h1F00, 1, d); chk("R7 boot->boot ok", d, 8'h5A);
    do_st(12'h100, 4'hF, rq, rj); chk("R6 mode01 store ok", rq, 1);
    erase();
    prog_lock(4'b0111);
    do_ld(16'h1F00, 0, d); chk("R7 app->boot blocked", d, 8'hFF);
    do_ld(16'h1F00, 1, d); chk("R7 boot->boot ok2", d, 8'h5A);
    erase();
  endtask

  task automatic t_boot();
    logic [7:0] d;
    boot_size_i = 2'b11; #1 chk("R8 size11", boot_start_o, 12'hF80);
    boot_size_i = 2'b10; #1 chk("R8 size10", boot_start_o, 12'hF00);
    boot_size_i = 2'b01; #1 chk("R8 size01", boot_start_o, 12'hE00);
    boot_size_i = 2'b00; #1 chk("R8 size00", boot_start_o, 12'hC00);
    @(negedge clk);
    prog_lock(4'b1101);
    do_ld(16'h1800, 1, d); chk("R8 first boot word", d, 8'h5A);
    do_ld(16'h17FE, 1, d); chk("R8 last app word", d, 8'hFF);
    erase();
    boot_size_i = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    t_reset();
    t_reads();
    t_window();
    t_lockset();
    t_store_prot();
    t_oneway();
    t_load_prot();
    t_boot();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule